// File: doc/BRIEF.md
# Banked Register File Address Resolver

This block turns a register-file operand into a physical data-memory address for a small core. The register file has two or four banks. Each bank has 32 locations. The number of banks is set by a parameter.

An instruction supplies a 5-bit location field. The block also holds an 8-bit bank/pointer register. That register gives the bank for every access. When the location field is zero, the pointer's low five bits also give the location, which is an indirect access. Locations 00h to 0Fh are shared by all banks and always resolve to bank 0. Only 10h to 1Fh are stored separately in each bank.

Location 00h is the indirect port and has no storage of its own. If an indirect access points back at it, a read returns zero and a write does nothing. Location 04h is the pointer register itself, so the block loads and reads it directly. All other locations go to the external RAM array. The block drives the RAM address and write enable for those locations and passes the RAM's read data through to the core.

Top module: `regbank_addr_mux`

## Requirements
- R1: After reset the pointer reads 8'h80 with four banks and 8'hC0 with two banks.
- R2: The pointer bits above the bank field are not stored and always read 1. These are bit 7 with four banks and bits 7:6 with two banks.
- R3: For a direct access to 10h–1Fh, `ram_addr` is the bank field joined above the 5-bit location. The bank field is pointer bits 6:5 with four banks and pointer bit 5 with two banks.
- R4: Any resolved location from 01h to 0Fh gives `ram_addr` equal to that location with the bank bits forced to 0.
- R5: When `loc_field` is 0, the resolved location is pointer bits 4:0. The bank rule of R3 and R4 then applies to it.
- R6: An indirect access that resolves to location 00h returns 00h on `rd_data`, whatever `ram_rdata` holds.
- R7: A write that resolves to location 00h leaves `ram_we` at 0 and leaves the pointer unchanged.
- R8: A write that resolves to location 04h (direct or indirect) loads the pointer at the next clock edge and leaves `ram_we` at 0. A read that resolves to 04h returns the pointer value.
- R9: `ram_we` equals `acc_wr` whenever the resolved location is neither 00h nor 04h, in the same cycle.
- R10: A read of any other resolved location returns `ram_rdata` unchanged in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loc_field | input | 5 | Location field from the instruction (0 selects indirect) |
| acc_wr | input | 1 | The current access is a write |
| wr_data | input | 8 | Write data |
| ram_rdata | input | 8 | Read data from the RAM array |
| ram_addr | output | 5+log2(NUM_BANKS) | Physical RAM address |
| ram_we | output | 1 | RAM write enable |
| rd_data | output | 8 | Read data returned to the core |
| ptr_value | output | 8 | Current pointer value, unimplemented bits as 1 |

## Verification
The outputs `ram_addr`, `ram_we` and `rd_data` are combinational, so they are due in the same cycle as the stimulus. The bench drives its inputs on the falling edge and samples these outputs one nanosecond later, before the next rising edge. A pointer load shows on `ptr_value` only after the following rising edge. Pointer checks are therefore taken at the falling edge after the write's clock edge, and ignored writes are confirmed at that same point. Two-bank and four-bank instances run side by side on the same inputs, each against its own expected address.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
   localparam int DATA_W   = 8;
   localparam int OFF_W    = 5;
   localparam logic [OFF_W-1:0] SELF_LOC = 5'h00;
   localparam logic [OFF_W-1:0] PTR_LOC  = 5'h04;

   typedef enum logic [1:0] {
      TGT_RAM  = 2'd0,
      TGT_SELF = 2'd1,
      TGT_PTR  = 2'd2
   } tgt_e;

   function automatic bit is_shared(input logic [OFF_W-1:0] off);
      return (off[OFF_W-1] == 1'b0);
   endfunction
endpackage

// File: rtl/regbank_ptr.sv
module regbank_ptr
   import regbank_pkg::*;
#(
   parameter int BANK_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ld,
   input  logic [OFF_W+BANK_W-1:0] ld_data,
   output logic [DATA_W-1:0]     ptr_q
);
   localparam int IMPL_W  = OFF_W + BANK_W;
   localparam int FILL_W  = DATA_W - IMPL_W;

   logic [IMPL_W-1:0] impl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  impl_q <= '0;
      else if (ld) impl_q <= ld_data;
   end

   generate
      if (FILL_W > 0) begin : g_fill
         assign ptr_q = {{FILL_W{1'b1}}, impl_q};
      end else begin : g_full
         assign ptr_q = impl_q;
      end
   endgenerate

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(ptr_q)) else $error("pointer moved without load"); // R7
   AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (ptr_q[IMPL_W-1:0] == $past(ld_data))) else $error("pointer load lost"); // R8
endmodule

// File: rtl/regbank_resolve.sv
module regbank_resolve
   import regbank_pkg::*;
#(
   parameter int BANK_W = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [OFF_W-1:0]          loc_field,
   input  logic                      acc_wr,
   input  logic [OFF_W+BANK_W-1:0]   ptr_impl,
   output logic [OFF_W+BANK_W-1:0]   ram_addr,
   output logic                      ram_we,
   output logic                      ptr_ld,
   output tgt_e                      target
);
   logic             indirect;
   logic [OFF_W-1:0] off;
   logic [BANK_W-1:0] bank;

   always_comb begin
      indirect = (loc_field == SELF_LOC);
      off      = indirect ? ptr_impl[OFF_W-1:0] : loc_field;
      bank     = is_shared(off) ? '0 : ptr_impl[OFF_W +: BANK_W];
      ram_addr = {bank, off};
      if (off == SELF_LOC)     target = TGT_SELF;
      else if (off == PTR_LOC) target = TGT_PTR;
      else                     target = TGT_RAM;
      ram_we = acc_wr && (target == TGT_RAM);
      ptr_ld = acc_wr && (target == TGT_PTR);
   end

   AST_WE_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_field == SELF_LOC && ptr_impl[OFF_W-1:0] == SELF_LOC) |-> !ram_we) else $error("self write reached RAM"); // R7
   AST_ALIAS_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_field[OFF_W-1] == 1'b0 && loc_field != SELF_LOC) |-> (ram_addr[OFF_W +: BANK_W] == '0)) else $error("shared location left bank 0"); // R4
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux
   import regbank_pkg::*;
(
   input  tgt_e              target,
   input  logic [DATA_W-1:0] ptr_q,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic [DATA_W-1:0] rd_data
);
   always_comb begin
      unique case (target)
         TGT_SELF: rd_data = '0;
         TGT_PTR:  rd_data = ptr_q;
         default:  rd_data = ram_rdata;
      endcase
   end
endmodule

// File: rtl/regbank_addr_mux.sv
module regbank_addr_mux
   import regbank_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   localparam int BANK_W   = $clog2(NUM_BANKS),
   localparam int PHYS_W   = OFF_W + BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        loc_field,
   input  logic              acc_wr,
   input  logic [7:0]        wr_data,
   input  logic [7:0]        ram_rdata,
   output logic [PHYS_W-1:0] ram_addr,
   output logic              ram_we,
   output logic [7:0]        rd_data,
   output logic [7:0]        ptr_value
);
   generate
      if (NUM_BANKS != 2 && NUM_BANKS != 4) begin : g_bad_cfg
         $error("NUM_BANKS must be 2 or 4");
      end
   endgenerate

   logic ptr_ld;
   tgt_e target;

   regbank_ptr #(.BANK_W(BANK_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (ptr_ld),
      .ld_data (wr_data[PHYS_W-1:0]),
      .ptr_q   (ptr_value)
   );

   regbank_resolve #(.BANK_W(BANK_W)) u_resolve (
      .clk       (clk),
      .rst_n     (rst_n),
      .loc_field (loc_field),
      .acc_wr    (acc_wr),
      .ptr_impl  (ptr_value[PHYS_W-1:0]),
      .ram_addr  (ram_addr),
      .ram_we    (ram_we),
      .ptr_ld    (ptr_ld),
      .target    (target)
   );

   regbank_rdmux u_rdmux (
      .target    (target),
      .ptr_q     (ptr_value),
      .ram_rdata (ram_rdata),
      .rd_data   (rd_data)
   );

   AST_SELF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_field == 5'h00 && ptr_value[4:0] == 5'h00) |-> (rd_data == 8'h00)) else $error("self read not zero"); // R6
   AST_UNIMPL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ptr_value[7:PHYS_W]) == (8 - PHYS_W)) else $error("unimplemented pointer bit low"); // R2
endmodule

// File: tb/regbank_addr_mux_tb.sv
module regbank_addr_mux_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] loc_field = 5'h10;
   logic       acc_wr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] ram_rdata = 8'h00;
   logic [6:0] addr4;
   logic [5:0] addr2;
   logic       we4, we2;
   logic [7:0] rd4, rd2, ptr4, ptr2;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   regbank_addr_mux #(.NUM_BANKS(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .loc_field(loc_field), .acc_wr(acc_wr),
      .wr_data(wr_data), .ram_rdata(ram_rdata), .ram_addr(addr4),
      .ram_we(we4), .rd_data(rd4), .ptr_value(ptr4));

   regbank_addr_mux #(.NUM_BANKS(2)) u_dut_b2 (
      .clk(clk), .rst_n(rst_n), .loc_field(loc_field), .acc_wr(acc_wr),
      .wr_data(wr_data), .ram_rdata(ram_rdata), .ram_addr(addr2),
      .ram_we(we2), .rd_data(rd2), .ptr_value(ptr2));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] model_ptr(input logic [7:0] v, input int bw);
      return (bw == 2) ? {1'b1, v[6:0]} : {2'b11, v[5:0]};
   endfunction

   function automatic logic [7:0] model_addr(input logic [4:0] d, input logic [7:0] p, input int bw);
      logic [4:0] off;
      logic [1:0] bank;
      off  = (d == 5'h00) ? p[4:0] : d;
      bank = (bw == 2) ? p[6:5] : {1'b0, p[5]};
      if (off < 5'h10) return {3'b000, off};
      return {1'b0, bank, off};
   endfunction

   // Load the pointer through a direct write to location 04h.
   task automatic set_ptr(input logic [7:0] v);
      @(negedge clk);
      loc_field = 5'h04; wr_data = v; acc_wr = 1'b1;
      @(negedge clk);
      acc_wr = 1'b0; loc_field = 5'h10;
   endtask

   task automatic probe(input logic [4:0] d, input logic [7:0] p, input string tag);
      @(negedge clk);
      loc_field = d;
      #1;
      chk({tag, " addr4"}, {1'b0, addr4}, model_addr(d, model_ptr(p, 2), 2));
      chk({tag, " addr2"}, {2'b00, addr2}, model_addr(d, model_ptr(p, 1), 1));
   endtask

   task automatic t_reset;
      #1;
      chk("R1 ptr4", ptr4, 8'h80);
      chk("R1 ptr2", ptr2, 8'hC0);
      chk("R9 idle we", {6'd0, we4, we2}, 8'h00);
   endtask

   task automatic t_unimpl;
      set_ptr(8'hFF);
      chk("R2 ptr4 ff", ptr4, 8'hFF);
      chk("R2 ptr2 ff", ptr2, 8'hFF);
      set_ptr(8'h00);
      chk("R2 ptr4 00", ptr4, 8'h80);
      chk("R2 ptr2 00", ptr2, 8'hC0);
      set_ptr(8'h35);
      chk("R2 ptr4 35", ptr4, 8'hB5);
      chk("R2 ptr2 35", ptr2, 8'hF5);
   endtask

   task automatic t_direct;
      set_ptr(8'h60);
      probe(5'h15, 8'h60, "R3 d15");
      chk("R3 addr4 15", {1'b0, addr4}, 8'h75);
      chk("R3 addr2 15", {2'b00, addr2}, 8'h35);
      for (int p = 0; p < 4; p++) begin
         set_ptr(8'(p << 5));
         probe(5'h1F, 8'(p << 5), "R3 d1f");
         probe(5'h10, 8'(p << 5), "R3 d10");
      end
   endtask

   task automatic t_alias;
      set_ptr(8'h60);
      probe(5'h0A, 8'h60, "R4 d0a");
      chk("R4 addr4 0a", {1'b0, addr4}, 8'h0A);
      acc_wr = 1'b1; wr_data = 8'h11; #1;
      chk("R9 we4 0a", {7'd0, we4}, 8'h01);
      chk("R9 we2 0a", {7'd0, we2}, 8'h01);
      @(negedge clk); acc_wr = 1'b0;
      probe(5'h01, 8'h60, "R4 d01");
   endtask

   task automatic t_indirect;
      set_ptr(8'h5C);
      ram_rdata = 8'hA5;
      probe(5'h00, 8'h5C, "R5 ind");
      chk("R5 addr4", {1'b0, addr4}, 8'h5C);
      chk("R5 addr2", {2'b00, addr2}, 8'h1C);
      chk("R10 rd4", rd4, 8'hA5);
      chk("R10 rd2", rd2, 8'hA5);
      set_ptr(8'h6B);
      probe(5'h00, 8'h6B, "R5 ind alias");
   endtask

   task automatic t_self;
      set_ptr(8'h20);
      ram_rdata = 8'hFF;
      @(negedge clk);
      loc_field = 5'h00; #1;
      chk("R6 rd4", rd4, 8'h00);
      chk("R6 rd2", rd2, 8'h00);
      acc_wr = 1'b1; wr_data = 8'h77; #1;
      chk("R7 we", {6'd0, we4, we2}, 8'h00);
      @(negedge clk);
      acc_wr = 1'b0; loc_field = 5'h10; #1;
      chk("R7 ptr4 kept", ptr4, 8'hA0);
      chk("R7 ptr2 kept", ptr2, 8'hE0);
   endtask

   task automatic t_ptr_access;
      set_ptr(8'h24);
      ram_rdata = 8'h5A;
      @(negedge clk);
      loc_field = 5'h00; #1;
      chk("R8 ind read4", rd4, 8'hA4);
      chk("R8 ind read2", rd2, 8'hE4);
      acc_wr = 1'b1; wr_data = 8'h13; #1;
      chk("R8 we", {6'd0, we4, we2}, 8'h00);
      @(negedge clk);
      acc_wr = 1'b0; loc_field = 5'h04; #1;
      chk("R8 ptr4 load", ptr4, 8'h93);
      chk("R8 ptr2 load", ptr2, 8'hD3);
      chk("R8 dir read4", rd4, 8'h93);
      loc_field = 5'h12; #1;
      chk("R10 rd4 direct", rd4, 8'h5A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_unimpl();
      t_direct();
      t_alias();
      t_indirect();
      t_self();
      t_ptr_access();
      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule